// File: doc/BRIEF.md
# Runtime Pin Multiplexing Matrix

This block joins a set of on-chip peripheral signals to a set of shared pads under software control. Every peripheral input has a select register that picks one pad or a fixed level. Every pad has a select register that picks one peripheral output, a fixed level, or a released (undriven) state. When a peripheral drives a pad, its output-enable travels with its data.

All selects sit behind a small register port with one access per cycle. Each select has a write-enable bit beside it. Software can clear that bit but can never set it again, so a clear freezes the routing of that entry until the next reset. The routing paths are combinational from the registered selects. A select write changes the routing from the cycle after the clock edge that stores it.

Top module: `pin_route_matrix`

## Requirements
- R1: An input select code of 0 holds the peripheral input at 0, and a code of 1 holds it at 1.
- R2: An input select code N with 2 <= N < NUM_PADS+2 makes the peripheral input follow pad input N-2.
- R3: A pad select code of 0 drives the pad with data 0 and enable 1. A code of 1 drives data 1 with enable 1.
- R4: A pad select code of 2 releases the pad: enable 0 and data 0.
- R5: A pad select code N with 3 <= N < NUM_PERIPH_OUT+3 drives the pad with the data and the enable of peripheral output N-3.
- R6: After reset, every input select reads 0, every pad select reads 2, and every write-enable bit reads 1.
- R7: An input code of NUM_PADS+2 or above gives a constant 0. A pad code of NUM_PERIPH_OUT+3 or above releases the pad (enable 0, data 0).
- R8: Asserting `cfg_lock_clr_i` clears the write-enable bit of the addressed entry. Nothing except reset sets it again.
- R9: A write to an entry whose write-enable bit is 0 leaves its select unchanged.
- R10: A write and a lock clear to the same unlocked entry in the same cycle both take effect. After that edge the entry holds the new code and its write-enable bit is 0.
- R11: `cfg_rdata_o` shows the addressed entry in the same cycle. Bit 7 is the write-enable bit and bits 6:0 are the select code, zero-extended for input selects. `cfg_space_i` = 0 addresses input selects and 1 addresses pad selects. A written code is stored at the clock edge.
- R12: An index beyond the entry count of the addressed space reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write the select code of the addressed entry |
| cfg_lock_clr_i | input | 1 | Clear the write-enable bit of the addressed entry |
| cfg_space_i | input | 1 | 0: input selects, 1: pad selects |
| cfg_idx_i | input | 3 | Entry index within the space |
| cfg_wdata_i | input | 7 | Select code to write |
| cfg_rdata_o | output | 8 | {write-enable bit, select code} of the addressed entry |
| pad_in_i | input | NUM_PADS | Levels received from the pads |
| periph_in_o | output | NUM_PERIPH_IN | Routed levels for the peripheral inputs |
| periph_out_i | input | NUM_PERIPH_OUT | Peripheral output data |
| periph_oe_i | input | NUM_PERIPH_OUT | Peripheral output enables |
| pad_out_o | output | NUM_PADS | Data driven toward each pad |
| pad_oe_o | output | NUM_PADS | Driver enable for each pad |

## Verification
Two things can happen to one entry in the same cycle: a select write and a lock clear. The bench provokes this on purpose on an unlocked pad entry. It also gets it by chance during random traffic. The check is that the new code lands and the entry reads as locked afterwards. A write can also reach an entry while that entry is still routing live traffic. The reference model compares every routed output on every cycle, so it confirms that the old code routes during the write cycle and the new code routes from the next one.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

   // Fixed codes at the bottom of each select space
   localparam int unsigned IN_FIXED_CODES  = 2;  // 0: low, 1: high
   localparam int unsigned PAD_CODE_LOW    = 0;
   localparam int unsigned PAD_CODE_HIGH   = 1;
   localparam int unsigned PAD_CODE_FREE   = 2;
   localparam int unsigned PAD_FIXED_CODES = 3;

   // Fixed-code entries of the flattened routing vectors
   localparam logic [1:0] IN_FIXED_DATA  = 2'b10;   // code1 -> 1, code0 -> 0
   localparam logic [2:0] PAD_FIXED_DATA = 3'b010;  // code2 -> 0, code1 -> 1, code0 -> 0
   localparam logic [2:0] PAD_FIXED_OE   = 3'b011;  // code2 released

   typedef enum logic {
      SPACE_INPUTS = 1'b0,
      SPACE_PADS   = 1'b1
   } cfg_space_e;

   function automatic int unsigned max_u(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pmx_sel_bank.sv
module pmx_sel_bank #(
   parameter int unsigned COUNT     = 8,
   parameter int unsigned SEL_W     = 6,
   parameter int unsigned IDX_W     = 3,
   parameter int unsigned DATA_W    = 7,
   parameter int unsigned RESET_SEL = 0
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        wr_i,
   input  logic                        clr_i,
   input  logic [IDX_W-1:0]            idx_i,
   input  logic [DATA_W-1:0]           wdata_i,
   output logic [COUNT-1:0][SEL_W-1:0] sel_o,
   output logic [SEL_W-1:0]            rd_sel_o,
   output logic                        rd_wen_o
);

   initial begin
      assert (COUNT >= 1) else $error("bank needs at least one entry");
      assert (COUNT <= (1 << IDX_W)) else $error("index too narrow for COUNT");
      assert (DATA_W >= SEL_W) else $error("write data narrower than select");
      assert (RESET_SEL < (1 << SEL_W)) else $error("reset code does not fit");
   end

   logic [COUNT-1:0][SEL_W-1:0] sel_q;
   logic [COUNT-1:0]            wen_q;

   for (genvar e = 0; e < COUNT; e++) begin : g_entry
      logic hit;
      assign hit = (idx_i == IDX_W'(e));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            sel_q[e] <= SEL_W'(RESET_SEL);
            wen_q[e] <= 1'b1;
         end else begin
            if (wr_i && hit && wen_q[e]) sel_q[e] <= wdata_i[SEL_W-1:0];
            if (clr_i && hit)            wen_q[e] <= 1'b0;
         end
      end

      // R8: a cleared write-enable bit stays cleared until reset
      assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !wen_q[e] |=> !wen_q[e]);

      // R9: a locked entry keeps its code
      assert_locked_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !wen_q[e] |=> $stable(sel_q[e]));

      // R10: a write and a clear in the same cycle both land
      assert_write_and_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (wr_i && clr_i && hit && wen_q[e]) |=>
            (sel_q[e] == $past(wdata_i[SEL_W-1:0])) && !wen_q[e]);
   end

   always_comb begin
      rd_sel_o = '0;
      rd_wen_o = 1'b0;
      for (int e = 0; e < COUNT; e++) begin
         if (idx_i == IDX_W'(e)) begin
            rd_sel_o = sel_q[e];
            rd_wen_o = wen_q[e];
         end
      end
   end

   assign sel_o = sel_q;

endmodule

// File: rtl/pmx_in_route.sv
module pmx_in_route
   import pmx_pkg::*;
#(
   parameter int unsigned NUM_PERIPH_IN = 8,
   parameter int unsigned NUM_PADS      = 6,
   parameter int unsigned SEL_W         = 6
) (
   input  logic [NUM_PERIPH_IN-1:0][SEL_W-1:0] sel_i,
   input  logic [NUM_PADS-1:0]                 pad_i,
   output logic [NUM_PERIPH_IN-1:0]            periph_o
);

   localparam int unsigned CODES = 1 << SEL_W;

   initial begin
      assert (NUM_PADS + IN_FIXED_CODES <= CODES) else $error("input select cannot reach every pad");
   end

   // One bit per code value; codes beyond the last pad read as zero
   logic [CODES-1:0] by_code;
   assign by_code = CODES'({pad_i, IN_FIXED_DATA});

   for (genvar p = 0; p < NUM_PERIPH_IN; p++) begin : g_periph
      assign periph_o[p] = by_code[sel_i[p]];
   end

endmodule

// File: rtl/pmx_out_route.sv
module pmx_out_route
   import pmx_pkg::*;
#(
   parameter int unsigned NUM_PADS       = 6,
   parameter int unsigned NUM_PERIPH_OUT = 10,
   parameter int unsigned SEL_W          = 7
) (
   input  logic [NUM_PADS-1:0][SEL_W-1:0] sel_i,
   input  logic [NUM_PERIPH_OUT-1:0]      data_i,
   input  logic [NUM_PERIPH_OUT-1:0]      oe_i,
   output logic [NUM_PADS-1:0]            pad_data_o,
   output logic [NUM_PADS-1:0]            pad_oe_o
);

   localparam int unsigned CODES = 1 << SEL_W;

   initial begin
      assert (NUM_PERIPH_OUT + PAD_FIXED_CODES <= CODES) else $error("pad select cannot reach every output");
   end

   // Codes past the last peripheral give data 0 and enable 0 (released)
   logic [CODES-1:0] data_by_code;
   logic [CODES-1:0] oe_by_code;
   assign data_by_code = CODES'({data_i, PAD_FIXED_DATA});
   assign oe_by_code   = CODES'({oe_i,   PAD_FIXED_OE});

   for (genvar d = 0; d < NUM_PADS; d++) begin : g_pad
      assign pad_data_o[d] = data_by_code[sel_i[d]];
      assign pad_oe_o[d]   = oe_by_code[sel_i[d]];
   end

endmodule

// File: rtl/pin_route_matrix.sv
module pin_route_matrix
   import pmx_pkg::*;
#(
   parameter int unsigned NUM_PERIPH_IN  = 8,
   parameter int unsigned NUM_PERIPH_OUT = 10,
   parameter int unsigned NUM_PADS       = 6,
   parameter int unsigned IN_SEL_W       = 6,
   parameter int unsigned OUT_SEL_W      = 7,
   localparam int unsigned MAX_ENTRIES   = max_u(max_u(NUM_PERIPH_IN, NUM_PADS), 2),
   localparam int unsigned IDX_W         = $clog2(MAX_ENTRIES),
   localparam int unsigned RD_W          = OUT_SEL_W + 1
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      cfg_we_i,
   input  logic                      cfg_lock_clr_i,
   input  logic                      cfg_space_i,
   input  logic [IDX_W-1:0]          cfg_idx_i,
   input  logic [OUT_SEL_W-1:0]      cfg_wdata_i,
   output logic [RD_W-1:0]           cfg_rdata_o,
   input  logic [NUM_PADS-1:0]       pad_in_i,
   output logic [NUM_PERIPH_IN-1:0]  periph_in_o,
   input  logic [NUM_PERIPH_OUT-1:0] periph_out_i,
   input  logic [NUM_PERIPH_OUT-1:0] periph_oe_i,
   output logic [NUM_PADS-1:0]       pad_out_o,
   output logic [NUM_PADS-1:0]       pad_oe_o
);

   initial begin
      assert (IN_SEL_W <= OUT_SEL_W) else $error("input select wider than write data");
      assert (NUM_PERIPH_IN >= 1 && NUM_PADS >= 1 && NUM_PERIPH_OUT >= 1)
         else $error("every count must be at least one");
   end

   logic in_space, pad_space;
   assign in_space  = (cfg_space_i == SPACE_INPUTS);
   assign pad_space = (cfg_space_i == SPACE_PADS);

   logic [NUM_PERIPH_IN-1:0][IN_SEL_W-1:0] in_sel;
   logic [NUM_PADS-1:0][OUT_SEL_W-1:0]     pad_sel;
   logic [IN_SEL_W-1:0]                    in_rd_sel;
   logic [OUT_SEL_W-1:0]                   pad_rd_sel;
   logic                                   in_rd_wen, pad_rd_wen;

   pmx_sel_bank #(
      .COUNT(NUM_PERIPH_IN), .SEL_W(IN_SEL_W), .IDX_W(IDX_W),
      .DATA_W(OUT_SEL_W), .RESET_SEL(0)
   ) u_in_bank (
      .clk_i, .rst_ni,
      .wr_i     (cfg_we_i && in_space),
      .clr_i    (cfg_lock_clr_i && in_space),
      .idx_i    (cfg_idx_i),
      .wdata_i  (cfg_wdata_i),
      .sel_o    (in_sel),
      .rd_sel_o (in_rd_sel),
      .rd_wen_o (in_rd_wen)
   );

   pmx_sel_bank #(
      .COUNT(NUM_PADS), .SEL_W(OUT_SEL_W), .IDX_W(IDX_W),
      .DATA_W(OUT_SEL_W), .RESET_SEL(PAD_CODE_FREE)
   ) u_pad_bank (
      .clk_i, .rst_ni,
      .wr_i     (cfg_we_i && pad_space),
      .clr_i    (cfg_lock_clr_i && pad_space),
      .idx_i    (cfg_idx_i),
      .wdata_i  (cfg_wdata_i),
      .sel_o    (pad_sel),
      .rd_sel_o (pad_rd_sel),
      .rd_wen_o (pad_rd_wen)
   );

   assign cfg_rdata_o = pad_space ? {pad_rd_wen, pad_rd_sel}
                                  : {in_rd_wen, OUT_SEL_W'(in_rd_sel)};

   pmx_in_route #(
      .NUM_PERIPH_IN(NUM_PERIPH_IN), .NUM_PADS(NUM_PADS), .SEL_W(IN_SEL_W)
   ) u_in_route (
      .sel_i    (in_sel),
      .pad_i    (pad_in_i),
      .periph_o (periph_in_o)
   );

   pmx_out_route #(
      .NUM_PADS(NUM_PADS), .NUM_PERIPH_OUT(NUM_PERIPH_OUT), .SEL_W(OUT_SEL_W)
   ) u_out_route (
      .sel_i      (pad_sel),
      .data_i     (periph_out_i),
      .oe_i       (periph_oe_i),
      .pad_data_o (pad_out_o),
      .pad_oe_o   (pad_oe_o)
   );

   for (genvar p = 0; p < NUM_PERIPH_IN; p++) begin : g_in_chk
      // R1: fixed input codes
      assert_in_fixed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (in_sel[p] < IN_SEL_W'(2)) |-> (periph_in_o[p] == in_sel[p][0]));
      // R7: unreachable input codes read zero
      assert_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (int'(in_sel[p]) >= NUM_PADS + 2) |-> !periph_in_o[p]);
   end

   for (genvar d = 0; d < NUM_PADS; d++) begin : g_pad_chk
      // R3: fixed pad codes drive actively
      assert_pad_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (pad_sel[d] < OUT_SEL_W'(2)) |-> (pad_oe_o[d] && pad_out_o[d] == pad_sel[d][0]));
      // R4: release code
      assert_pad_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (pad_sel[d] == OUT_SEL_W'(PAD_CODE_FREE)) |-> (!pad_oe_o[d] && !pad_out_o[d]));
      // R7: unreachable pad codes release the pad
      assert_pad_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (int'(pad_sel[d]) >= NUM_PERIPH_OUT + 3) |-> (!pad_oe_o[d] && !pad_out_o[d]));
   end

endmodule

// File: tb/sim_pin_route_matrix.sv
`timescale 1ns/1ps
module sim_pin_route_matrix;

   localparam int NPI = 8;
   localparam int NPO = 10;
   localparam int NP  = 6;
   localparam int ISW = 6;
   localparam int OSW = 7;
   localparam int IW  = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           we = 1'b0, clr = 1'b0, space = 1'b0;
   logic [IW-1:0]  idx = '0;
   logic [OSW-1:0] wdata = '0;
   logic [OSW:0]   rdata;
   logic [NP-1:0]  pad_in = '0;
   logic [NPI-1:0] pin;
   logic [NPO-1:0] pout = '0, poe = '0;
   logic [NP-1:0]  pad_out, pad_oe;

   always #2 clk = ~clk;

   pin_route_matrix u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .cfg_we_i(we), .cfg_lock_clr_i(clr), .cfg_space_i(space),
      .cfg_idx_i(idx), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
      .pad_in_i(pad_in), .periph_in_o(pin),
      .periph_out_i(pout), .periph_oe_i(poe),
      .pad_out_o(pad_out), .pad_oe_o(pad_oe)
   );

   // Reference state
   int     m_in_sel  [NPI];
   bit     m_in_wen  [NPI];
   int     m_pad_sel [NP];
   bit     m_pad_wen [NP];
   int     n_checks = 0, n_fail = 0;
   string  rd_tag = "R11";
   bit     finished = 1'b0;

   task automatic m_reset();
      for (int i = 0; i < NPI; i++) begin m_in_sel[i] = 0; m_in_wen[i] = 1'b1; end
      for (int i = 0; i < NP; i++)  begin m_pad_sel[i] = 2; m_pad_wen[i] = 1'b1; end
   endtask

   task automatic check(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int cnt, exp_rd;
      for (int p = 0; p < NPI; p++) begin
         int s = m_in_sel[p];
         int e;
         string t;
         if (s < 2) begin e = s; t = "R1"; end
         else if (s - 2 < NP) begin e = int'(pad_in[s-2]); t = "R2"; end
         else begin e = 0; t = "R7"; end
         check(t, $sformatf("periph_in[%0d] code %0d", p, s), int'(pin[p]), e);
      end
      for (int d = 0; d < NP; d++) begin
         int s = m_pad_sel[d];
         int ed, eo;
         string t;
         if (s < 2)  begin ed = s; eo = 1; t = "R3"; end
         else if (s == 2) begin ed = 0; eo = 0; t = "R4"; end
         else if (s - 3 < NPO) begin ed = int'(pout[s-3]); eo = int'(poe[s-3]); t = "R5"; end
         else begin ed = 0; eo = 0; t = "R7"; end
         check(t, $sformatf("pad[%0d] {oe,data} code %0d", d, s),
               int'({pad_oe[d], pad_out[d]}), eo * 2 + ed);
      end
      cnt = space ? NP : NPI;
      if (int'(idx) >= cnt) begin
         check("R12", $sformatf("rdata space %0d idx %0d", space, idx), int'(rdata), 0);
      end else begin
         if (space) exp_rd = int'(m_pad_wen[idx]) * 128 + m_pad_sel[idx];
         else       exp_rd = int'(m_in_wen[idx]) * 128 + m_in_sel[idx];
         check(rd_tag, $sformatf("rdata space %0d idx %0d", space, idx), int'(rdata), exp_rd);
      end
   endtask

   // One cycle: drive after the falling edge, compare, then advance the model at the rising edge
   task automatic cyc(bit r, bit w, bit c, bit sp, int ix, int wd);
      @(negedge clk);
      rst_n = r; we = w; clr = c; space = sp;
      idx = IW'(ix); wdata = OSW'(wd);
      pad_in = NP'($urandom); pout = NPO'($urandom); poe = NPO'($urandom);
      if (!r) m_reset();
      #1;
      compare_all();
      @(posedge clk);
      if (r) begin
         int cnt = sp ? NP : NPI;
         if (ix < cnt) begin
            if (sp) begin
               if (w && m_pad_wen[ix]) m_pad_sel[ix] = wd % 128;
               if (c) m_pad_wen[ix] = 1'b0;
            end else begin
               if (w && m_in_wen[ix]) m_in_sel[ix] = wd % 64;
               if (c) m_in_wen[ix] = 1'b0;
            end
         end
      end
   endtask

   task automatic read_all(string tag);
      rd_tag = tag;
      for (int i = 0; i < NPI; i++) cyc(1, 0, 0, 0, i, 0);
      for (int i = 0; i < NP; i++)  cyc(1, 0, 0, 1, i, 0);
      rd_tag = "R11";
   endtask

   initial begin
      m_reset();
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0);
      // R6: reset state of all entries
      read_all("R6");

      // R1 R2 R7: input codes across the whole range, live pad traffic
      begin
         int codes [NPI] = '{0, 1, 2, 4, 7, 8, 63, 3};
         for (int i = 0; i < NPI; i++) cyc(1, 1, 0, 0, i, codes[i]);
         for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, i % NPI, 0);
      end

      // R3 R4 R5 R7: pad codes
      for (int c = 0; c < 16; c++) begin
         cyc(1, 1, 0, 1, c % NP, c);
         cyc(1, 0, 0, 1, c % NP, 0);
      end
      cyc(1, 1, 0, 1, 5, 127);
      for (int i = 0; i < 6; i++) cyc(1, 0, 0, 1, i, 0);

      // R9: write, lock, attempted rewrite
      cyc(1, 1, 0, 1, 0, 5);
      cyc(1, 0, 1, 1, 0, 0);
      rd_tag = "R9";
      cyc(1, 1, 0, 1, 0, 7);
      cyc(1, 0, 0, 1, 0, 0);
      cyc(1, 1, 0, 0, 3, 9);
      cyc(1, 1, 0, 0, 3, 1);
      rd_tag = "R8";
      cyc(1, 0, 1, 0, 3, 0);
      for (int i = 0; i < 8; i++) cyc(1, 1, 0, 0, 3, i + 2);
      cyc(1, 0, 0, 0, 3, 0);

      // R10: write and clear in the same cycle
      rd_tag = "R10";
      cyc(1, 1, 1, 1, 1, 4);
      cyc(1, 0, 0, 1, 1, 0);
      cyc(1, 1, 0, 1, 1, 9);
      cyc(1, 0, 0, 1, 1, 0);
      rd_tag = "R11";

      // R12: indices past the pad bank
      cyc(1, 1, 1, 1, 6, 3);
      cyc(1, 1, 0, 1, 7, 1);
      cyc(1, 0, 0, 1, 6, 0);
      read_all("R12");

      // R11: random mixed traffic
      for (int i = 0; i < 400; i++) begin
         bit sp = 1'($urandom);
         cyc(1, 1'($urandom), ($urandom_range(0, 19) == 0), sp,
             $urandom_range(0, 7), sp ? $urandom_range(0, 15) : $urandom_range(0, 9));
      end

      // R6: second reset restores codes and write-enable bits
      cyc(0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0);
      read_all("R6");
      for (int i = 0; i < 4; i++) cyc(1, 1, 0, 1, i, i + 3);
      for (int i = 0; i < 4; i++) cyc(1, 0, 0, 1, i, 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule